// File: doc/BRIEF.md
# Display pipeline update mutex controller

This block coordinates atomic configuration changes across the modules of a display pipeline. It holds a bank of independent lock instances. Each instance owns a set of member modules and a frame-sync source choice. Software enables an instance and requests its lock, then polls until the grant bit reads 1. It then rewrites the shadow registers of the member modules and releases the lock. While an instance is held, its members see a hold signal that stops any shadow-to-active transfer.

On release, the members receive a one-cycle "apply configuration" strobe. The strobe fires at once in single mode. Otherwise it waits for the next rising edge of the selected start-of-frame input, and the holds stay asserted until then. Membership is a 64-bit mask spread over two 32-bit words. Software edits the mask by read-modify-write, so every register reads back exactly what was written.

Top module: `disp_mutex_ctrl`

## Requirements
- R1: After synchronous reset, `upd_strobe` and `mod_hold` are zero and every instance reads back enable 0, grant 0, masks 0 and frame-sync code 0.
- R2: Instance n (0..9) has registers at byte address 0x20+0x20*n plus an offset: enable +0x00 (bit 0), lock +0x04, reset +0x08, mask-low +0x0C, frame-sync code +0x10 (bits 2:0), mask-high +0x14. Read data appears on `bus_rdata` one cycle after the address is presented.
- R3: Writing 1 to lock on an enabled instance sets grant, which reads back as bit 1 of the lock register from the next cycle on.
- R4: A lock request on a disabled instance is never granted, and enabling the instance later does not grant the old request.
- R5: While an instance is granted or has a pending commit, `mod_hold` carries its member mask, one cycle after the grant register. Holds from several instances are ORed.
- R6: In single mode (code 0), writing 0 to lock on a granted instance raises `upd_strobe` to the member mask for exactly one cycle, starting the cycle after the write. The hold stays up during that cycle and drops the cycle after.
- R7: With code k in 1..6, a release makes no strobe until the next rising edge of `sof_in[k-1]`. The strobe appears in the cycle after that edge. Pulses on other inputs are ignored, and the holds stay asserted meanwhile. Code 3 selects `sof_in[2]`.
- R8: Frame-sync codes 7 and above behave as single mode.
- R9: Module IDs below 32 map to bit ID of mask-low. IDs 32 and above map to bit ID-32 of mask-high. Both words read back exactly as written, so a read-modify-write that adds one bit leaves the others unchanged.
- R10: Writing 1 to the reset register clears that instance's grant, pending commit and holds without a strobe. Its masks and frame-sync code are kept.
- R11: Writing 0 to enable drops that instance's grant and pending commit without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| sof_in | input | 6 | Start-of-frame inputs, code k selects bit k-1 |
| upd_strobe | output | 64 | Per-module apply-configuration pulse |
| mod_hold | output | 64 | Per-module hold of shadow transfer |

## Verification
The bench builds the block with its default parameters: ten instances, six frame-sync inputs and a 64-bit module space. With these values, member bits on both sides of the word boundary, the reserved code 7, the last instance's address slot and several instances held at once are all reachable. A scoreboard queue holds every strobe the bench expects, so a stray strobe during a deferred wait, after a lock reset or after a disable is reported when it happens.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int SEL_W = 3;
  typedef enum logic [2:0] {
    RK_EN   = 3'd0,
    RK_LOCK = 3'd1,
    RK_RST  = 3'd2,
    RK_MLO  = 3'd3,
    RK_SOF  = 3'd4,
    RK_MHI  = 3'd5
  } reg_kind_e;
endpackage

// File: rtl/dmx_decode.sv
module dmx_decode
  import dmx_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_INST = 10,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              valid,
  output logic [IDX_W-1:0]  idx,
  output reg_kind_e         kind
);
  localparam int BLK_W = ADDR_W - 5;
  logic [BLK_W-1:0] blk;

  always_comb begin
    blk   = addr[ADDR_W-1:5];
    kind  = reg_kind_e'(addr[4:2]);
    idx   = IDX_W'(blk - BLK_W'(1));
    valid = (blk >= BLK_W'(1)) && (blk <= BLK_W'(N_INST)) &&
            (addr[1:0] == 2'b00) && (addr[4:2] <= 3'd5);
  end
endmodule

// File: rtl/dmx_sof_edge.sv
module dmx_sof_edge #(
  parameter int N_SOF = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SOF-1:0] sof_in,
  output logic [N_SOF-1:0] sof_rise
);
  logic [N_SOF-1:0] sof_q;

  always_ff @(posedge clk) begin
    if (rst) sof_q <= '0;
    else     sof_q <= sof_in;
  end

  assign sof_rise = sof_in & ~sof_q;
endmodule

// File: rtl/dmx_slot.sv
module dmx_slot
  import dmx_pkg::*;
#(
  parameter int MOD_W = 64,
  parameter int N_SOF = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  reg_kind_e        kind,
  input  logic [31:0]      wdata,
  input  logic [N_SOF-1:0] sof_rise,
  output logic             en_o,
  output logic             req_o,
  output logic             grant_o,
  output logic             pend_o,
  output logic [MOD_W-1:0] mask_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             fire_o
);
  localparam int HI_W = MOD_W - 32;

  logic             en_q, req_q, grant_q, pend_q;
  logic [MOD_W-1:0] mask_q;
  logic [SEL_W-1:0] sel_q;
  logic             is_sync, sync_hit, release_now, kill;

  // frame-synced only for codes 1..N_SOF; everything else acts as single mode
  always_comb begin
    is_sync  = (sel_q != '0) && (int'(sel_q) <= N_SOF);
    sync_hit = 1'b0;
    for (int k = 0; k < N_SOF; k++)
      if (int'(sel_q) == k + 1) sync_hit = sof_rise[k];
    release_now = wr_hit && (kind == RK_LOCK) && !wdata[0] && grant_q;
    kill = wr_hit && (((kind == RK_RST) && wdata[0]) ||
                      ((kind == RK_EN) && !wdata[0]));
    fire_o = (release_now && !is_sync) || (pend_q && sync_hit && !kill);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      req_q   <= 1'b0;
      grant_q <= 1'b0;
      pend_q  <= 1'b0;
      mask_q  <= '0;
      sel_q   <= '0;
    end else begin
      if (pend_q && sync_hit) pend_q <= 1'b0;
      if (wr_hit) begin
        case (kind)
          RK_EN: begin
            en_q <= wdata[0];
            if (!wdata[0]) begin
              grant_q <= 1'b0;
              pend_q  <= 1'b0;
              req_q   <= 1'b0;
            end
          end
          RK_LOCK: begin
            if (wdata[0]) begin
              req_q <= 1'b1;
              if (en_q) grant_q <= 1'b1;
            end else begin
              req_q <= 1'b0;
              if (grant_q) begin
                grant_q <= 1'b0;
                if (is_sync) pend_q <= 1'b1;
              end
            end
          end
          RK_RST: begin
            if (wdata[0]) begin
              grant_q <= 1'b0;
              pend_q  <= 1'b0;
              req_q   <= 1'b0;
            end
          end
          RK_MLO:  mask_q[31:0]      <= wdata;
          RK_SOF:  sel_q             <= wdata[SEL_W-1:0];
          RK_MHI:  mask_q[MOD_W-1:32] <= wdata[HI_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign en_o    = en_q;
  assign req_o   = req_q;
  assign grant_o = grant_q;
  assign pend_o  = pend_q;
  assign mask_o  = mask_q;
  assign sel_o   = sel_q;
endmodule

// File: rtl/disp_mutex_ctrl.sv
module disp_mutex_ctrl
  import dmx_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_INST = 10,
  parameter int N_SOF  = 6,
  parameter int MOD_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_SOF-1:0]  sof_in,
  output logic [MOD_W-1:0]  upd_strobe,
  output logic [MOD_W-1:0]  mod_hold
);
  localparam int IDX_W = $clog2(N_INST);
  localparam int HI_W  = MOD_W - 32;

  logic             dec_valid;
  logic [IDX_W-1:0] dec_idx;
  reg_kind_e        dec_kind;
  logic [N_SOF-1:0] sof_rise;

  logic [N_INST-1:0] en_v, req_v, grant_v, pend_v, fire_v;
  logic [MOD_W-1:0]  mask_a [N_INST];
  logic [SEL_W-1:0]  sel_a  [N_INST];
  logic [MOD_W-1:0]  hold_d, strobe_d;
  logic [31:0]       rdata_d;

  dmx_decode #(.ADDR_W(ADDR_W), .N_INST(N_INST), .IDX_W(IDX_W)) u_dec (
    .addr(bus_addr), .valid(dec_valid), .idx(dec_idx), .kind(dec_kind)
  );

  dmx_sof_edge #(.N_SOF(N_SOF)) u_sof (
    .clk(clk), .rst(rst), .sof_in(sof_in), .sof_rise(sof_rise)
  );

  for (genvar i = 0; i < N_INST; i++) begin : g_slot
    dmx_slot #(.MOD_W(MOD_W), .N_SOF(N_SOF)) u_slot (
      .clk(clk), .rst(rst),
      .wr_hit(bus_wr && dec_valid && (dec_idx == IDX_W'(i))),
      .kind(dec_kind), .wdata(bus_wdata), .sof_rise(sof_rise),
      .en_o(en_v[i]), .req_o(req_v[i]), .grant_o(grant_v[i]),
      .pend_o(pend_v[i]), .mask_o(mask_a[i]), .sel_o(sel_a[i]),
      .fire_o(fire_v[i])
    );
  end

  always_comb begin
    hold_d   = '0;
    strobe_d = '0;
    for (int i = 0; i < N_INST; i++) begin
      if (grant_v[i] || pend_v[i]) hold_d   = hold_d | mask_a[i];
      if (fire_v[i])               strobe_d = strobe_d | mask_a[i];
    end
  end

  always_comb begin
    rdata_d = '0;
    if (dec_valid && (int'(dec_idx) < N_INST)) begin
      case (dec_kind)
        RK_EN:   rdata_d = {31'd0, en_v[dec_idx]};
        RK_LOCK: rdata_d = {30'd0, grant_v[dec_idx], req_v[dec_idx]};
        RK_MLO:  rdata_d = mask_a[dec_idx][31:0];
        RK_SOF:  rdata_d = {{(32-SEL_W){1'b0}}, sel_a[dec_idx]};
        RK_MHI:  rdata_d = 32'(mask_a[dec_idx][MOD_W-1:32]);
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_strobe <= '0;
      mod_hold   <= '0;
      bus_rdata  <= '0;
    end else begin
      upd_strobe <= strobe_d;
      mod_hold   <= hold_d;
      bus_rdata  <= rdata_d;
    end
  end
endmodule

// File: rtl/dmx_checker.sv
module dmx_checker #(
  parameter int N_INST = 10,
  parameter int MOD_W  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [N_INST-1:0] grant_v,
  input logic [N_INST-1:0] pend_v,
  input logic [MOD_W-1:0]  upd_strobe,
  input logic [MOD_W-1:0]  mod_hold
);
  // R1: the cycle after reset the outputs are quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (upd_strobe == '0) && (mod_hold == '0));

  // R3: a new grant only follows a lock write carrying 1
  p_grant_from_write_r3: assert property (@(posedge clk) disable iff (rst)
    ((grant_v & ~$past(grant_v)) != '0) |-> $past(bus_wr && bus_wdata[0]));

  // R5: no held or pending instance means no hold one cycle later
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    ((grant_v | pend_v) == '0) |=> (mod_hold == '0));

  // R6: a strobed module is still held in the strobe cycle
  p_strobe_in_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ((upd_strobe & ~mod_hold) == '0));

  // R7: a commit becomes pending only from a granted instance
  p_pend_from_grant_r7: assert property (@(posedge clk) disable iff (rst)
    ((pend_v & ~$past(pend_v) & ~$past(grant_v)) == '0));
endmodule

bind disp_mutex_ctrl dmx_checker #(.N_INST(N_INST), .MOD_W(MOD_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .grant_v(grant_v), .pend_v(pend_v),
  .upd_strobe(upd_strobe), .mod_hold(mod_hold)
);

// File: tb/disp_mutex_ctrl_bench.sv
module disp_mutex_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  sof_in = '0;
  logic [63:0] upd_strobe, mod_hold;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_q [$];
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_mutex_ctrl u_disp_mutex_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sof_in(sof_in),
    .upd_strobe(upd_strobe), .mod_hold(mod_hold)
  );

  function automatic logic [11:0] ra(input int n, input int off);
    return 12'(32 + 32 * n + off);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse(input int k);
    @(negedge clk);
    sof_in[k] = 1'b1;
    @(negedge clk);
    sof_in[k] = 1'b0;
  endtask

  // scoreboard monitor: every strobe must match the oldest expectation
  always @(negedge clk) begin
    if (!rst && upd_strobe != '0) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6/R7 unexpected strobe actual=%h expected=%h", upd_strobe, 64'h0);
      end else begin
        chk("R6/R7 strobe", upd_strobe, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 strobe", upd_strobe, 64'h0);
    chk("R1 hold", mod_hold, 64'h0);
    rd(ra(1, 4), rv);  chk("R1 lock", 64'(rv), 64'h0);
    rd(ra(9, 20), rv); chk("R1 mask-high", 64'(rv), 64'h0);

    // R2/R3/R5/R6 single mode acquire, poll, release on instance 1
    wr(ra(1, 12), 32'h0000_0810);
    wr(ra(1, 20), 32'h0);
    wr(ra(1, 0), 32'h1);
    wr(ra(1, 4), 32'h1);
    rd(ra(1, 4), rv);  chk("R3 grant bit", 64'(rv[1]), 64'h1);
    chk("R5 hold while granted", mod_hold, 64'h810);
    exp_q.push_back(64'h810);
    wr(ra(1, 4), 32'h0);
    chk("R6 hold in strobe cycle", mod_hold, 64'h810);
    @(negedge clk);
    chk("R6 one-cycle strobe", upd_strobe, 64'h0);
    chk("R6 hold dropped", mod_hold, 64'h0);

    // R4 request on disabled instance 4
    wr(ra(4, 12), 32'h1);
    wr(ra(4, 4), 32'h1);
    rd(ra(4, 4), rv);  chk("R4 no grant disabled", 64'(rv[1]), 64'h0);
    wr(ra(4, 0), 32'h1);
    rd(ra(4, 4), rv);  chk("R4 no grant after enable", 64'(rv[1]), 64'h0);
    chk("R4 no hold", mod_hold, 64'h0);

    // R7/R9 deferred commit on DPI0 (code 3 -> sof_in[2]), modules 5 and 33
    wr(ra(2, 12), 32'h20);
    wr(ra(2, 20), 32'h2);
    wr(ra(2, 16), 32'h3);
    wr(ra(2, 0), 32'h1);
    wr(ra(2, 4), 32'h1);
    wr(ra(2, 4), 32'h0);
    @(negedge clk);
    chk("R7 hold while pending", mod_hold, 64'h0000_0002_0000_0020);
    chk("R7 no early strobe", upd_strobe, 64'h0);
    pulse(0);
    pulse(1);
    @(negedge clk);
    chk("R7 other source ignored", mod_hold, 64'h0000_0002_0000_0020);
    exp_q.push_back(64'h0000_0002_0000_0020);
    pulse(2);
    @(negedge clk);
    chk("R7 hold released", mod_hold, 64'h0);

    // R9 read-modify-write keeps other bits
    rd(ra(2, 12), rv);
    wr(ra(2, 12), rv | 32'h1);
    rd(ra(2, 12), rv); chk("R9 low word rmw", 64'(rv), 64'h21);
    rd(ra(2, 20), rv);
    wr(ra(2, 20), rv | 32'h8000_0000);
    rd(ra(2, 20), rv); chk("R9 high word rmw", 64'(rv), 64'h8000_0002);

    // R10 reset during pending commit (code 4 -> sof_in[3])
    wr(ra(3, 12), 32'h0000_4000);
    wr(ra(3, 16), 32'h4);
    wr(ra(3, 0), 32'h1);
    wr(ra(3, 4), 32'h1);
    wr(ra(3, 4), 32'h0);
    @(negedge clk);
    chk("R10 pending hold", mod_hold, 64'h4000);
    wr(ra(3, 8), 32'h1);
    @(negedge clk);
    chk("R10 hold cleared", mod_hold, 64'h0);
    pulse(3);
    @(negedge clk);
    chk("R10 no strobe", upd_strobe, 64'h0);
    rd(ra(3, 12), rv); chk("R10 mask kept", 64'(rv), 64'h4000);
    rd(ra(3, 16), rv); chk("R10 code kept", 64'(rv), 64'h4);

    // R8 reserved code 7 acts as single mode
    wr(ra(5, 12), 32'h0000_0003);
    wr(ra(5, 16), 32'h7);
    wr(ra(5, 0), 32'h1);
    wr(ra(5, 4), 32'h1);
    exp_q.push_back(64'h3);
    wr(ra(5, 4), 32'h0);
    @(negedge clk);
    chk("R8 strobe done", upd_strobe, 64'h0);

    // R11 disable drops grant without strobe
    wr(ra(6, 20), 32'h0000_0100);
    wr(ra(6, 0), 32'h1);
    wr(ra(6, 4), 32'h1);
    @(negedge clk);
    chk("R11 hold granted", mod_hold, 64'h0000_0100_0000_0000);
    wr(ra(6, 0), 32'h0);
    @(negedge clk);
    chk("R11 hold dropped", mod_hold, 64'h0);
    rd(ra(6, 4), rv);  chk("R11 grant dropped", 64'(rv[1]), 64'h0);

    // R5/R2 two instances held at once, last slot at 0x140
    wr(ra(0, 12), 32'h0000_00F0);
    wr(ra(0, 0), 32'h1);
    wr(ra(0, 4), 32'h1);
    wr(ra(9, 12), 32'h0001_0000);
    wr(ra(9, 20), 32'h0000_0001);
    wr(ra(9, 0), 32'h1);
    wr(ra(9, 4), 32'h1);
    @(negedge clk);
    chk("R5 ORed holds", mod_hold, 64'h0000_0001_0001_00F0);
    rd(12'h144, rv);   chk("R2 slot 9 lock", 64'(rv[1]), 64'h1);
    exp_q.push_back(64'h0000_0001_0001_0000);
    wr(ra(9, 4), 32'h0);
    @(negedge clk);
    chk("R5 remaining hold", mod_hold, 64'h00F0);
    exp_q.push_back(64'h00F0);
    wr(ra(0, 4), 32'h0);

    repeat (3) @(negedge clk);
    chk("R6 all expected strobes seen", 64'(exp_q.size()), 64'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule